// File: doc/BRIEF.md
# GF(2^4) Result Rotation Pipeline

This block is the last step of a pipelined finite-field multiplier and divider. An earlier stage delivers an intermediate field element and an exponent. Only the low bits of the exponent reach this block. They give the residual count of multiply-by-alpha steps, from 0 to 3, needed to turn the intermediate element into the final product or quotient. The block applies those steps in a fixed three-stage pipeline and accepts a new element every clock cycle.

Each stage holds one multiply-by-alpha circuit, a compare of the carried count against the stage's own threshold, and a 2:1 select. A per-item input picks the field polynomial: x^4+x+1 or x^4+x^3+1. The count, the polynomial choice and a valid flag are registered with the element at every stage, so items that follow each other back to back do not disturb one another. When the valid flag is low, meaning one operand was zero, the output element is zero.

Top module: `gf_rot_pipe`

## Requirements
- R1: An item presented at the inputs appears at the outputs exactly 3 rising clock edges later, and a new item can be accepted on every cycle.
- R2: With rot_cnt = 0 and a high valid flag, out_elem equals in_elem.
- R3: With poly_sel = 0, out_elem equals in_elem multiplied by alpha rot_cnt times, modulo x^4+x+1. One step is a left shift by one bit; if bit 3 was set, the result is then XORed with 4'b0011.
- R4: With poly_sel = 1, the same rotation uses x^4+x^3+1. If bit 3 was set, the shifted value is XORed with 4'b1001.
- R5: out_vld equals the in_vld that was presented with the same item, 3 cycles earlier.
- R6: Whenever out_vld is low, out_elem is 4'b0000, whatever element and count were presented.
- R7: During and directly after reset, out_vld is 0 and out_elem is 0.
- R8: In a back-to-back stream, each item is rotated by its own count and under its own polynomial choice, independently of its neighbours.
- R9: A nonzero element that is presented with a high valid flag always yields a nonzero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Item valid; low means the result is zero |
| in_elem | input | 4 | Intermediate field element |
| in_cnt | input | 2 | Low bits of the result power: number of alpha steps |
| in_psel | input | 1 | Polynomial choice: 0 selects x^4+x+1, 1 selects x^4+x^3+1 |
| out_vld | output | 1 | Valid flag of the result |
| out_elem | output | 4 | Final product or quotient element |

## Verification
The bench builds the block with its defaults: a 4-bit element width, a 2-bit count and three stages. With these values both polynomials can be swept over every element and every count. Directed streams then mix counts, polynomials and valid flags on consecutive cycles. This exposes any stage that acts on a count or select belonging to a neighbouring item, and any gap in the zero forcing on invalid slots.

// File: rtl/gf_rot_pkg.sv
package gf_rot_pkg;

    // Polynomial choice carried with each item
    typedef enum logic {
        PSEL_TRINOM_LOW  = 1'b0,
        PSEL_TRINOM_HIGH = 1'b1
    } psel_e;

    localparam int unsigned DEF_ELEM_W = 4;
    // Reduction terms (coefficients below x^m)
    localparam logic [DEF_ELEM_W-1:0] DEF_RED_LOW  = 4'b0011; // x^4+x+1
    localparam logic [DEF_ELEM_W-1:0] DEF_RED_HIGH = 4'b1001; // x^4+x^3+1

endpackage

// File: rtl/gf_alpha_mul.sv
module gf_alpha_mul
    import gf_rot_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter logic [ELEM_W-1:0] RED_LOW  = DEF_RED_LOW,
    parameter logic [ELEM_W-1:0] RED_HIGH = DEF_RED_HIGH
) (
    input  logic [ELEM_W-1:0] elem_i,
    input  psel_e             psel_i,
    output logic [ELEM_W-1:0] elem_o
);

    logic [ELEM_W-1:0] red_term;
    logic [ELEM_W-1:0] shifted;

    always_comb begin
        red_term = (psel_i == PSEL_TRINOM_HIGH) ? RED_HIGH : RED_LOW;
        shifted  = {elem_i[ELEM_W-2:0], 1'b0};
        elem_o   = elem_i[ELEM_W-1] ? (shifted ^ red_term) : shifted;
    end

    // Multiplying by a nonzero field element never yields zero
    always_comb begin
        assert_alpha_nonzero_R9: assert ((elem_i == '0) == (elem_o == '0))
            else $error("alpha step changed zero-ness of element");
    end

endmodule

// File: rtl/gf_rot_stage.sv
module gf_rot_stage
    import gf_rot_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter int unsigned CNT_W  = 2,
    parameter int unsigned THRESH = 1,
    parameter logic [ELEM_W-1:0] RED_LOW  = DEF_RED_LOW,
    parameter logic [ELEM_W-1:0] RED_HIGH = DEF_RED_HIGH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  psel_e             psel_i,
    output logic              vld_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic [CNT_W-1:0]  cnt_o,
    output psel_e             psel_o
);

    localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(THRESH);

    typedef struct packed {
        logic              vld;
        logic [ELEM_W-1:0] elem;
        logic [CNT_W-1:0]  cnt;
        psel_e             psel;
    } stage_t;

    stage_t            st_d, st_q;
    logic [ELEM_W-1:0] rot_elem;
    logic              do_rot;

    gf_alpha_mul #(
        .ELEM_W   (ELEM_W),
        .RED_LOW  (RED_LOW),
        .RED_HIGH (RED_HIGH)
    ) i_alpha (
        .elem_i (elem_i),
        .psel_i (psel_i),
        .elem_o (rot_elem)
    );

    always_comb begin
        do_rot    = (cnt_i >= THRESH_C);
        st_d.vld  = vld_i;
        st_d.cnt  = cnt_i;
        st_d.psel = psel_i;
        if (!vld_i) begin
            st_d.elem = '0;
        end else if (do_rot) begin
            st_d.elem = rot_elem;
        end else begin
            st_d.elem = elem_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, elem: '0, cnt: '0, psel: PSEL_TRINOM_LOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign elem_o = st_q.elem;
    assign cnt_o  = st_q.cnt;
    assign psel_o = st_q.psel;

    // Marks cycles whose previous edge was already out of reset
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_vld_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (vld_o == $past(vld_i)))
        else $error("valid flag not forwarded");

    assert_hold_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(vld_i) && ($past(cnt_i) < THRESH_C))
            |-> (elem_o == $past(elem_i)))
        else $error("stage altered element below its threshold");

    assert_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(vld_i) && ($past(elem_i) != '0)) |-> (elem_o != '0))
        else $error("nonzero element became zero");

    assert_cnt_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (cnt_o == $past(cnt_i) && psel_o == $past(psel_i)))
        else $error("count or polynomial choice not carried with item");

endmodule

// File: rtl/gf_rot_pipe.sv
module gf_rot_pipe
    import gf_rot_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter int unsigned CNT_W  = 2,
    parameter logic [ELEM_W-1:0] RED_LOW  = DEF_RED_LOW,
    parameter logic [ELEM_W-1:0] RED_HIGH = DEF_RED_HIGH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [ELEM_W-1:0] in_elem,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic              in_psel,
    output logic              out_vld,
    output logic [ELEM_W-1:0] out_elem
);

    localparam int unsigned N_STAGE = (1 << CNT_W) - 1;

    logic              vld_w  [N_STAGE+1];
    logic [ELEM_W-1:0] elem_w [N_STAGE+1];
    logic [CNT_W-1:0]  cnt_w  [N_STAGE+1];
    psel_e             psel_w [N_STAGE+1];

    assign vld_w[0]  = in_vld;
    assign elem_w[0] = in_elem;
    assign cnt_w[0]  = in_cnt;
    assign psel_w[0] = psel_e'(in_psel);

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        gf_rot_stage #(
            .ELEM_W   (ELEM_W),
            .CNT_W    (CNT_W),
            .THRESH   (s + 1),
            .RED_LOW  (RED_LOW),
            .RED_HIGH (RED_HIGH)
        ) i_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_w[s]),
            .elem_i (elem_w[s]),
            .cnt_i  (cnt_w[s]),
            .psel_i (psel_w[s]),
            .vld_o  (vld_w[s+1]),
            .elem_o (elem_w[s+1]),
            .cnt_o  (cnt_w[s+1]),
            .psel_o (psel_w[s+1])
        );
    end

    assign out_vld  = vld_w[N_STAGE];
    assign out_elem = elem_w[N_STAGE];

    assert_zero_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_elem == '0))
        else $error("invalid slot carries nonzero element");

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R7: assert (!out_vld && out_elem == '0)
                else $error("outputs not cleared in reset");
        end
    end

endmodule

// File: tb/test_gf_rot_pipe.sv
module test_gf_rot_pipe;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] in_elem = '0;
    logic [1:0] in_cnt = '0;
    logic       in_psel = 1'b0;
    logic       out_vld;
    logic [3:0] out_elem;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    gf_rot_pipe i_gf_rot_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_elem  (in_elem),
        .in_cnt   (in_cnt),
        .in_psel  (in_psel),
        .out_vld  (out_vld),
        .out_elem (out_elem)
    );

    // Independent reference: repeated multiply by alpha
    function automatic logic [3:0] ref_rot(logic [3:0] e, logic [1:0] c, logic s);
        logic [3:0] r = e;
        for (int i = 0; i < int'(c); i++) begin
            r = r[3] ? ({r[2:0], 1'b0} ^ (s ? 4'b1001 : 4'b0011)) : {r[2:0], 1'b0};
        end
        return r;
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got vld/elem=%b expected %b", req, act, exp);
        end
    endtask

    // Stream buffer, filled by each scenario
    logic       sv_vld  [64];
    logic [3:0] sv_elem [64];
    logic [1:0] sv_cnt  [64];
    logic       sv_psel [64];

    // Drive n items back to back; output of item t is sampled at negedge t+3
    task automatic run_stream(string req, int n);
        for (int t = 0; t < n + 3; t++) begin
            @(negedge clk);
            if (t >= 3) begin
                int k = t - 3;
                logic [3:0] e = sv_vld[k] ? ref_rot(sv_elem[k], sv_cnt[k], sv_psel[k]) : 4'b0;
                check(req, {out_vld, out_elem}, {sv_vld[k], e});
            end
            if (t < n) begin
                in_vld  = sv_vld[t];
                in_elem = sv_elem[t];
                in_cnt  = sv_cnt[t];
                in_psel = sv_psel[t];
            end else begin
                in_vld = 1'b0; in_elem = '0; in_cnt = '0; in_psel = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 in reset", {out_vld, out_elem}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after reset", {out_vld, out_elem}, 5'b0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_vld = 1'b1; in_elem = 4'b1000; in_cnt = 2'd1; in_psel = 1'b0;
        @(negedge clk);
        in_vld = 1'b0; in_elem = '0; in_cnt = '0;
        @(negedge clk);
        check("R1 not yet at edge 2", {out_vld, out_elem}, 5'b0);
        @(negedge clk);
        check("R1 at edge 3", {out_vld, out_elem}, {1'b1, 4'b0011});
        @(negedge clk);
        check("R1 single item gone", {out_vld, out_elem}, 5'b0);
    endtask

    task automatic t_identity();
        for (int i = 0; i < 16; i++) begin
            sv_vld[i] = 1'b1; sv_elem[i] = 4'(i); sv_cnt[i] = 2'd0; sv_psel[i] = i[0];
        end
        run_stream("R2 zero count", 16);
    endtask

    task automatic t_poly(logic s, string req);
        for (int i = 0; i < 64; i++) begin
            sv_vld[i] = 1'b1; sv_elem[i] = 4'(i % 16); sv_cnt[i] = 2'(i / 16); sv_psel[i] = s;
        end
        run_stream(req, 64);
    endtask

    task automatic t_valid();
        for (int i = 0; i < 32; i++) begin
            sv_vld[i] = (i % 3 != 0); sv_elem[i] = 4'((i * 7 + 3) % 16);
            sv_cnt[i] = 2'(i % 4); sv_psel[i] = i[2];
        end
        run_stream("R5 R6 valid gating", 32);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 48; i++) begin
            sv_vld[i] = 1'b1; sv_elem[i] = 4'((i * 5 + 1) % 16);
            sv_cnt[i] = 2'((i * 3) % 4); sv_psel[i] = i[0] ^ i[3];
        end
        run_stream("R8 mixed stream", 48);
    endtask

    task automatic t_nonzero();
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int e = 1; e < 16; e++) begin
                    logic [3:0] r = ref_rot(4'(e), 2'(c), s[0]);
                    n_checks++;
                    if (r == 4'b0) begin
                        n_errors++;
                        $display("FAIL R9: got %b expected nonzero", r);
                    end
                end
            end
        end
        sv_vld[0] = 1'b1; sv_elem[0] = 4'b1000; sv_cnt[0] = 2'd3; sv_psel[0] = 1'b1;
        sv_vld[1] = 1'b1; sv_elem[1] = 4'b0001; sv_cnt[1] = 2'd3; sv_psel[1] = 1'b0;
        run_stream("R9 nonzero result", 2);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_identity();
        t_poly(1'b0, "R3 poly x4+x+1");
        t_poly(1'b1, "R4 poly x4+x3+1");
        t_valid();
        t_mixed();
        t_nonzero();
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hang expected completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule